// File: doc/BRIEF.md
# Address Remap Decoder

This block turns a 32-bit bus address from one of several masters into a slave target code. Four address windows can be steered to boot flash, DDR or the external AXI port according to a 6-bit remap value and a separate flash swap bit. The rest of the space decodes through a fixed map. Two of the remap bits limit where the CPU masters and the peripheral-port master may go. A control bit makes the scratch RAM window read-only, and writes into it are then flagged.

The decode is combinational. By default an output register captures the result one cycle after a valid request. The bus wrapper uses the target code to route the request. It turns the decode-error flag into an error response and suppresses any write that the block flags as blocked.

Top module: `addr_remap_decoder`

## Requirements
- R1: After reset, the outputs are all zero: valid 0, target 0, error 0, block 0. A request with `in_valid_i` high appears on the outputs exactly one clock later with `out_valid_o` high. In a cycle where `in_valid_i` is low, `out_valid_o` falls to 0 one clock later and the target, error and block outputs keep their previous values.
- R2: Default mode, when none of `remap_i[5:2]` are set. Window A (0x00000000–0x03FFFFFF) goes to boot flash, window B (0x04000000–0x3FFFFFFF) goes to DDR, and windows C (0x60000000–0x7FFFFFFF) and D (0xC0000000–0xFFEFFFFF) go to external AXI. Boot flash is code 1 (chip select 0) when `flash_swap_i`=0 and code 2 (chip select 1) when it is 1. DDR is code 3 and external AXI is code 4.
- R3: When `remap_i[2]`=1, windows A,B,C,D go to DDR, DDR, external AXI, external AXI. Bits 5..3 have no effect in this case.
- R4: When `remap_i[3:2]`=10, windows A,B,C,D go to external AXI, external AXI, DDR, DDR. Bits 5..4 have no effect in this case.
- R5: When `remap_i[4:2]`=100, all four windows go to DDR. Bit 5 has no effect in this case.
- R6: When `remap_i[5:2]`=1000, windows A,B,C,D go to boot flash (chip select chosen as in R2), DDR, DDR, DDR.
- R7: Outside the four windows the map is fixed and independent of the remap value:
  - 0x40000000–0x4FFFFFFF: board static memory, code 5.
  - 0x50000000–0x50FFFFFF: scratch RAM, code 6.
  - 0x80000000–0x9FFFFFFF: DDR, code 3.
  - 0xA0000000–0xAFFFFFFF: on-chip peripherals, code 7.
  - 0xB0000000–0xBFFFFFFF: board peripherals, code 8.
  - Everything else is unmapped.
- R8: When `remap_i[0]`=1, a request from master 0 or 1 (the CPUs, on `master_i`) is a decode error if its address is 0x80000000 or above and below 0xFF000000.
- R9: When `remap_i[1]`=1, a request from master 2 (the peripheral port) is a decode error if its address is below 0x80000000. Master 3 is never restricted.
- R10: A write (`is_write_i`=1) that decodes to scratch RAM while `ro_scratch_i`=1 raises `wr_block_o`. The target stays code 6. Reads, and writes with the bit clear, are not blocked.
- R11: An unmapped address, or a master window violation, raises `dec_err_o`. It also forces target code 0 and `wr_block_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request present; loads the output register |
| addr_i | input | 32 | Request address |
| is_write_i | input | 1 | 1 for a write request |
| master_i | input | 2 | 0/1 CPU, 2 peripheral port, 3 other |
| remap_i | input | 6 | Remap control value |
| flash_swap_i | input | 1 | Selects boot flash chip select 1 |
| ro_scratch_i | input | 1 | Scratch RAM is read-only |
| out_valid_o | output | 1 | Decoded result valid |
| target_o | output | 4 | Target code |
| dec_err_o | output | 1 | Decode error |
| wr_block_o | output | 1 | Write to protected scratch RAM |

## Verification
Several faults show up at the ports one cycle after the request that exposes them:
- A wrong priority between remap bits puts the wrong target on the output. It is visible only for remap values with more than one of bits 5..2 set, so the stimulus mixes those patterns in.
- A boundary off by one misdecodes only at the first or last address of a window. The bench drives every window edge under every mode.
- A failing clock enable or reset appears as a changed output after an idle cycle, or as a nonzero output straight after reset.

// File: rtl/adrmap_pkg.sv
package adrmap_pkg;
  localparam int ADDR_W = 32;
  localparam int REMAP_W = 6;
  localparam int SEL_LO = 2;
  localparam int NUM_SEL = REMAP_W - SEL_LO;
  localparam int TGT_W = 4;

  typedef enum logic [TGT_W-1:0] {
    TGT_NONE     = 4'd0,
    TGT_FLASH0   = 4'd1,
    TGT_FLASH1   = 4'd2,
    TGT_DDR      = 4'd3,
    TGT_EXTAXI   = 4'd4,
    TGT_BOARDMEM = 4'd5,
    TGT_SCRATCH  = 4'd6,
    TGT_ONCHIP   = 4'd7,
    TGT_BOARDIO  = 4'd8
  } tgt_e;

  typedef enum logic [2:0] {
    WIN_A, WIN_B, WIN_C, WIN_D, WIN_FIXED
  } win_e;

  typedef enum logic [2:0] {
    MAP_DEFAULT, MAP_ALT1, MAP_ALT2, MAP_ALT3, MAP_ALT4
  } map_e;

  typedef enum logic [1:0] {
    MST_CPU0, MST_CPU1, MST_PPORT, MST_OTHER
  } mst_e;

  localparam logic [ADDR_W-1:0] A_LO_END    = 32'h0400_0000;
  localparam logic [ADDR_W-1:0] B_END       = 32'h4000_0000;
  localparam logic [ADDR_W-1:0] C_START     = 32'h6000_0000;
  localparam logic [ADDR_W-1:0] HALF_START  = 32'h8000_0000;
  localparam logic [ADDR_W-1:0] D_START     = 32'hC000_0000;
  localparam logic [ADDR_W-1:0] D_END       = 32'hFFF0_0000;
  localparam logic [ADDR_W-1:0] TOP_START   = 32'hFF00_0000;
  localparam logic [ADDR_W-1:0] BMEM_END    = 32'h5000_0000;
  localparam logic [ADDR_W-1:0] SCR_END     = 32'h5100_0000;
  localparam logic [ADDR_W-1:0] DDRF_END    = 32'hA000_0000;
  localparam logic [ADDR_W-1:0] ONCHIP_END  = 32'hB000_0000;
  localparam logic [ADDR_W-1:0] BIO_END     = 32'hC000_0000;
endpackage

// File: rtl/adrmap_window.sv
module adrmap_window
  import adrmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output tgt_e              fixed_tgt
);
  always_comb begin
    if (addr < A_LO_END)                            win = WIN_A;
    else if (addr < B_END)                          win = WIN_B;
    else if (addr >= C_START && addr < HALF_START)  win = WIN_C;
    else if (addr >= D_START && addr < D_END)       win = WIN_D;
    else                                            win = WIN_FIXED;
  end

  always_comb begin
    if (addr >= B_END && addr < BMEM_END)                fixed_tgt = TGT_BOARDMEM;
    else if (addr >= BMEM_END && addr < SCR_END)         fixed_tgt = TGT_SCRATCH;
    else if (addr >= HALF_START && addr < DDRF_END)      fixed_tgt = TGT_DDR;
    else if (addr >= DDRF_END && addr < ONCHIP_END)      fixed_tgt = TGT_ONCHIP;
    else if (addr >= ONCHIP_END && addr < BIO_END)       fixed_tgt = TGT_BOARDIO;
    else                                                 fixed_tgt = TGT_NONE;
  end
endmodule

// File: rtl/adrmap_mode.sv
module adrmap_mode
  import adrmap_pkg::*;
(
  input  logic [NUM_SEL-1:0] sel_bits,
  input  logic               flash_swap,
  input  win_e               win,
  input  tgt_e               fixed_tgt,
  output map_e               mode,
  output tgt_e               raw_tgt
);
  tgt_e flash_t;
  assign flash_t = flash_swap ? TGT_FLASH1 : TGT_FLASH0;

  // lowest set select bit wins; scan from the top so lower bits overwrite
  always_comb begin
    mode = MAP_DEFAULT;
    for (int k = NUM_SEL - 1; k >= 0; k--) begin
      if (sel_bits[k]) mode = map_e'(3'(k + 1));
    end
  end

  always_comb begin
    raw_tgt = fixed_tgt;
    if (win != WIN_FIXED) begin
      unique case (mode)
        MAP_ALT1: raw_tgt = (win == WIN_A || win == WIN_B) ? TGT_DDR : TGT_EXTAXI;
        MAP_ALT2: raw_tgt = (win == WIN_A || win == WIN_B) ? TGT_EXTAXI : TGT_DDR;
        MAP_ALT3: raw_tgt = TGT_DDR;
        MAP_ALT4: raw_tgt = (win == WIN_A) ? flash_t : TGT_DDR;
        default: begin
          if (win == WIN_A)      raw_tgt = flash_t;
          else if (win == WIN_B) raw_tgt = TGT_DDR;
          else                   raw_tgt = TGT_EXTAXI;
        end
      endcase
    end
  end
endmodule

// File: rtl/adrmap_guard.sv
module adrmap_guard
  import adrmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        restrict_en,
  input  mst_e              master,
  input  logic              is_write,
  input  logic              ro_scratch,
  input  tgt_e              raw_tgt,
  output tgt_e              tgt,
  output logic              dec_err,
  output logic              wr_block
);
  logic cpu_m, pport_m, cpu_bad, pport_bad;

  assign cpu_m     = (master == MST_CPU0) || (master == MST_CPU1);
  assign pport_m   = (master == MST_PPORT);
  assign cpu_bad   = restrict_en[0] && cpu_m && addr >= HALF_START && addr < TOP_START;
  assign pport_bad = restrict_en[1] && pport_m && addr < HALF_START;

  always_comb begin
    dec_err  = cpu_bad || pport_bad || (raw_tgt == TGT_NONE);
    tgt      = dec_err ? TGT_NONE : raw_tgt;
    wr_block = !dec_err && is_write && ro_scratch && (raw_tgt == TGT_SCRATCH);
  end
endmodule

// File: rtl/addr_remap_decoder.sv
module addr_remap_decoder
  import adrmap_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [31:0]       addr_i,
  input  logic              is_write_i,
  input  logic [1:0]        master_i,
  input  logic [5:0]        remap_i,
  input  logic              flash_swap_i,
  input  logic              ro_scratch_i,
  output logic              out_valid_o,
  output logic [3:0]        target_o,
  output logic              dec_err_o,
  output logic              wr_block_o
);
  win_e win_c;
  tgt_e fixed_c, raw_c, tgt_c;
  map_e mode_c;
  logic err_c, blk_c;

  adrmap_window u_win (.addr(addr_i), .win(win_c), .fixed_tgt(fixed_c));

  adrmap_mode u_mode (
    .sel_bits(remap_i[REMAP_W-1:SEL_LO]), .flash_swap(flash_swap_i),
    .win(win_c), .fixed_tgt(fixed_c), .mode(mode_c), .raw_tgt(raw_c)
  );

  adrmap_guard u_guard (
    .addr(addr_i), .restrict_en(remap_i[1:0]), .master(mst_e'(master_i)),
    .is_write(is_write_i), .ro_scratch(ro_scratch_i), .raw_tgt(raw_c),
    .tgt(tgt_c), .dec_err(err_c), .wr_block(blk_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic v_q, v_d, e_q, e_d, b_q, b_d, ld_en;
      tgt_e t_q, t_d;

      assign ld_en = in_valid_i;

      always_comb begin
        v_d = in_valid_i;
        t_d = tgt_c;
        e_d = err_c;
        b_d = blk_c;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          t_q <= TGT_NONE;
          e_q <= 1'b0;
          b_q <= 1'b0;
        end else begin
          v_q <= v_d;
          if (ld_en) begin
            t_q <= t_d;
            e_q <= e_d;
            b_q <= b_d;
          end
        end
      end

      assign out_valid_o = v_q;
      assign target_o    = t_q;
      assign dec_err_o   = e_q;
      assign wr_block_o  = b_q;

      p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
      p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(target_o) && $stable(dec_err_o) && $stable(wr_block_o) && !out_valid_o));
      p_cpu_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && remap_i[0] && !master_i[1] && addr_i[31] && addr_i[31:24] != 8'hFF) |=> dec_err_o);
      p_pport_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && remap_i[1] && master_i == 2'd2 && !addr_i[31]) |=> dec_err_o);
      p_err_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o |-> (target_o == 4'd0 && !wr_block_o));
      p_block_scratch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block_o |-> target_o == 4'd6);
    end else begin : g_comb
      assign out_valid_o = in_valid_i;
      assign target_o    = tgt_c;
      assign dec_err_o   = err_c;
      assign wr_block_o  = blk_c;
    end
  endgenerate

  logic unused_mode;
  assign unused_mode = ^mode_c;
endmodule

// File: tb/addr_remap_decoder_test.sv
module addr_remap_decoder_test;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid_i, is_write_i, flash_swap_i, ro_scratch_i;
  logic [31:0] addr_i;
  logic [1:0] master_i;
  logic [5:0] remap_i;
  logic out_valid_o, dec_err_o, wr_block_o;
  logic [3:0] target_o;

  int checks = 0;
  int errors = 0;

  logic       ev, ee, eb;
  logic [3:0] et;
  string      etag;

  always #2ns clk = ~clk;

  addr_remap_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .addr_i(addr_i),
    .is_write_i(is_write_i), .master_i(master_i), .remap_i(remap_i),
    .flash_swap_i(flash_swap_i), .ro_scratch_i(ro_scratch_i),
    .out_valid_o(out_valid_o), .target_o(target_o), .dec_err_o(dec_err_o),
    .wr_block_o(wr_block_o)
  );

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h03FF_FFFF;  2: return 32'h0400_0000;
      3: return 32'h3FFF_FFFF;  4: return 32'h4000_0000;  5: return 32'h4FFF_FFFF;
      6: return 32'h5000_0000;  7: return 32'h50FF_FFFF;  8: return 32'h5100_0000;
      9: return 32'h5FFF_FFFF; 10: return 32'h6000_0000; 11: return 32'h7FFF_FFFF;
     12: return 32'h8000_0000; 13: return 32'h9FFF_FFFF; 14: return 32'hA000_0000;
     15: return 32'hAFFF_FFFF; 16: return 32'hB000_0000; 17: return 32'hBFFF_FFFF;
     18: return 32'hC000_0000; 19: return 32'hFEFF_FFFF; 20: return 32'hFF00_0000;
     21: return 32'hFFEF_FFFF; 22: return 32'hFFF0_0000; default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic ref_model(input logic [31:0] a, input logic [5:0] rm, input logic sw,
                           input logic [1:0] m, input logic wr, input logic ro,
                           output logic [3:0] t, output logic e, output logic b,
                           output string tag);
    int mode, w;
    logic [3:0] fl, dd, ex;
    fl = sw ? 4'd2 : 4'd1; dd = 4'd3; ex = 4'd4;
    if (rm[2]) mode = 1; else if (rm[3]) mode = 2; else if (rm[4]) mode = 3;
    else if (rm[5]) mode = 4; else mode = 0;
    if (a < 32'h0400_0000) w = 0;
    else if (a < 32'h4000_0000) w = 1;
    else if (a >= 32'h6000_0000 && a < 32'h8000_0000) w = 2;
    else if (a >= 32'hC000_0000 && a < 32'hFFF0_0000) w = 3;
    else w = 4;
    if (w < 4) begin
      case (mode)
        0: begin t = (w == 0) ? fl : (w == 1) ? dd : ex; tag = "R2"; end
        1: begin t = (w < 2) ? dd : ex; tag = "R3"; end
        2: begin t = (w < 2) ? ex : dd; tag = "R4"; end
        3: begin t = dd; tag = "R5"; end
        default: begin t = (w == 0) ? fl : dd; tag = "R6"; end
      endcase
    end else begin
      tag = "R7";
      if (a >= 32'h4000_0000 && a < 32'h5000_0000) t = 4'd5;
      else if (a >= 32'h5000_0000 && a < 32'h5100_0000) t = 4'd6;
      else if (a >= 32'h8000_0000 && a < 32'hA000_0000) t = 4'd3;
      else if (a >= 32'hA000_0000 && a < 32'hB000_0000) t = 4'd7;
      else if (a >= 32'hB000_0000 && a < 32'hC000_0000) t = 4'd8;
      else t = 4'd0;
    end
    e = 1'b0;
    if (rm[0] && m < 2 && a >= 32'h8000_0000 && a < 32'hFF00_0000) begin e = 1'b1; tag = "R8"; end
    else if (rm[1] && m == 2 && a < 32'h8000_0000) begin e = 1'b1; tag = "R9"; end
    else if (t == 4'd0) begin e = 1'b1; tag = "R11"; end
    if (e) t = 4'd0;
    b = !e && wr && ro && t == 4'd6;
    if (!e && wr && t == 4'd6) tag = "R10";
  endtask

  task automatic check_now();
    checks++;
    if (out_valid_o !== ev || target_o !== et || dec_err_o !== ee || wr_block_o !== eb) begin
      errors++;
      $display("FAIL %s actual v=%0b t=%0d e=%0b b=%0b expected v=%0b t=%0d e=%0b b=%0b",
               etag, out_valid_o, target_o, dec_err_o, wr_block_o, ev, et, ee, eb);
    end
  endtask

  // check the previous cycle's result, then present a new request
  task automatic step(input logic v, input logic [31:0] a, input logic [5:0] rm,
                      input logic sw, input logic [1:0] m, input logic wr, input logic ro);
    @(negedge clk);
    check_now();
    in_valid_i = v; addr_i = a; remap_i = rm; flash_swap_i = sw;
    master_i = m; is_write_i = wr; ro_scratch_i = ro;
    ev = v;
    if (v) ref_model(a, rm, sw, m, wr, ro, et, ee, eb, etag);
    else etag = "R1";
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] modes [6];
    modes = '{6'h00, 6'h3C, 6'h38, 6'h30, 6'h20, 6'h04};
    rst_n = 1'b0; in_valid_i = 0; addr_i = 0; remap_i = 0; flash_swap_i = 0;
    master_i = 0; is_write_i = 0; ro_scratch_i = 0;
    ev = 0; et = 0; ee = 0; eb = 0; etag = "R1";
    repeat (3) @(negedge clk);
    check_now();  // R1 reset state
    rst_n = 1'b1;
    // every window edge under every mode and both swap values (R2-R7, R11)
    for (int mi = 0; mi < 6; mi++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 24; c++)
          step(1'b1, corner(c), modes[mi], s[0], 2'd3, 1'b0, 1'b0);
    // R8 CPU window, R9 peripheral port window
    for (int c = 0; c < 24; c++) begin
      step(1'b1, corner(c), 6'h01, 1'b0, 2'd0, 1'b0, 1'b0);
      step(1'b1, corner(c), 6'h01, 1'b1, 2'd1, 1'b0, 1'b0);
      step(1'b1, corner(c), 6'h02, 1'b0, 2'd2, 1'b0, 1'b0);
      step(1'b1, corner(c), 6'h03, 1'b0, 2'd3, 1'b0, 1'b0);
    end
    // R10 scratch write protection
    step(1'b1, 32'h5000_0010, 6'h00, 1'b0, 2'd3, 1'b1, 1'b1);
    step(1'b1, 32'h50FF_FFFC, 6'h00, 1'b0, 2'd0, 1'b0, 1'b1);
    step(1'b1, 32'h5000_0010, 6'h00, 1'b0, 2'd3, 1'b1, 1'b0);
    step(1'b1, 32'h5100_0000, 6'h00, 1'b0, 2'd3, 1'b1, 1'b1);
    // R1 hold over idle cycles
    step(1'b0, 32'h0000_0000, 6'h3F, 1'b1, 2'd2, 1'b1, 1'b1);
    step(1'b0, 32'hFFFF_FFFF, 6'h00, 1'b0, 2'd0, 1'b0, 1'b0);
    // mixed stimulus
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      a = ($urandom_range(0, 1) == 0) ? corner($urandom_range(0, 23)) : $urandom;
      step(($urandom_range(0, 7) != 0), a, 6'($urandom), 1'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    check_now();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule